// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Byte Buffer

This block is a 16-byte staging buffer placed between a byte-wide processor data register and a serial card data-line engine. The storage is two 8-byte banks used in turn. The producer fills one bank completely while the consumer drains the other. Each bank then changes role.

Each bank reports its own empty and full status. A single interrupt line is the OR of those four flags, each gated by its own enable bit.

Two software controls abort a transfer in progress:

- One control returns the write-side pointer to its start.
- The other control returns the read-side pointer to its start.

While either control is held, both ports stall. When it is released, every bank is empty again. For a complete restart, software raises both controls together.

Top module: `pingpong_fifo`

## Requirements
- R1: After reset, `bank_empty` is 2'b11, `bank_full` is 2'b00, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Bytes are stored in bank 0 at offsets 0..7, then in bank 1 at offsets 0..7, and then back to bank 0. Reads use the same order, so bytes leave in the order they arrived.
- R3: A bank's full flag (bit b of `bank_full` for bank b) is 1 from the cycle after the eighth byte is accepted into that bank. Its empty flag clears in the cycle after the first byte is accepted into it.
- R4: A bank's empty flag (bit b of `bank_empty`) is 1 from the cycle after its eighth byte is read. Its full flag clears in the cycle after the first byte is read from it.
- R5: A bank can be read only after it has been filled. A partly written bank keeps `rd_valid` at 0. No bank is ever flagged both empty and full.
- R6: When both banks are full, `wr_ready` is 0, and offered bytes neither overwrite nor displace stored data.
- R7: When the bank at the read pointer holds no complete data (for example, both banks empty), `rd_valid` is 0 and no byte is repeated.
- R8: In the same cycle, a byte can be written into one bank while a byte is read from the other bank.
- R9: While `wr_ptr_clr` is 1, `wr_ready` and `rd_valid` are 0. One cycle after it rises, every bank is empty and none is full. After release, the next byte written goes to bank 0, offset 0.
- R10: While `rd_ptr_clr` is 1, `rd_valid` and `wr_ready` are 0. One cycle after it rises, every bank is empty and none is full.
- R11: `irq` is 1 exactly when an enabled flag is set. The enable bits are: `irq_en[0]` for bank 0 empty, `irq_en[1]` for bank 1 empty, `irq_en[2]` for bank 0 full, and `irq_en[3]` for bank 1 full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Byte accepted on this edge when wr_valid is 1 |
| wr_data | input | 8 | Byte to store |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Consumer takes the byte on this edge |
| rd_data | output | 8 | Byte at the read pointer |
| wr_ptr_clr | input | 1 | Holds the write pointer at its start and aborts the transfer |
| rd_ptr_clr | input | 1 | Holds the read pointer at its start and aborts the transfer |
| irq_en | input | 4 | Per-flag interrupt enables |
| bank_empty | output | 2 | Empty flag per bank |
| bank_full | output | 2 | Full flag per bank |
| irq | output | 1 | OR of enabled, set flags |

## Verification
A write and a read can both be accepted in one cycle, because each targets a different bank. The test first fills bank 0. For the next eight cycles it then offers a new byte and requests a read together. Each of those cycles must show both handshakes complete, the read returning the expected bank-0 byte. Afterwards, draining bank 1 must return the eight bytes written during the overlap, in order. A pointer clear raised in the middle of a transfer competes with the handshakes. The test requires both ports to stall while the clear is held, and data written after the release to come back from the first offset.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_FILL  = 2'd1,
    BK_FULL  = 2'd2,
    BK_DRAIN = 2'd3
  } bank_st_e;

  function automatic logic bank_writable(input bank_st_e s);
    return (s == BK_EMPTY) || (s == BK_FILL);
  endfunction

  function automatic logic bank_readable(input bank_st_e s);
    return (s == BK_FULL) || (s == BK_DRAIN);
  endfunction

  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pp_ptr.sv
module pp_ptr #(
  parameter int BANKS = 2,
  parameter int DEPTH = 8,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int OFF_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              last_o
);
  import pp_fifo_pkg::*;

  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;

  assign last_o = (int'(off_q) == DEPTH - 1);
  assign bank_o = bank_q;
  assign off_o  = off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      off_q  <= '0;
    end else if (clr) begin
      bank_q <= '0;
      off_q  <= '0;
    end else if (adv) begin
      if (last_o) begin
        off_q  <= '0;
        bank_q <= BANK_W'(ring_next(int'(bank_q), BANKS));
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pp_bank_state.sv
module pp_bank_state (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  wr_hit,
  input  logic                  wr_last,
  input  logic                  rd_hit,
  input  logic                  rd_last,
  output pp_fifo_pkg::bank_st_e st_o
);
  import pp_fifo_pkg::*;

  bank_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (abort) begin
      st_d = BK_EMPTY;
    end else if (wr_hit && bank_writable(st_q)) begin
      st_d = wr_last ? BK_FULL : BK_FILL;
    end else if (rd_hit && bank_readable(st_q)) begin
      st_d = rd_last ? BK_EMPTY : BK_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BK_EMPTY;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

endmodule

// File: rtl/pp_irq.sv
module pp_irq #(
  parameter int SRCS = 4
) (
  input  logic [SRCS-1:0] flags,
  input  logic [SRCS-1:0] en,
  output logic            irq
);
  assign irq = |(flags & en);
endmodule

// File: rtl/pingpong_fifo.sv
module pingpong_fifo #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 2,
  parameter int DEPTH  = 8,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int OFF_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IRQ_N  = 2 * BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_ptr_clr,
  input  logic              rd_ptr_clr,
  input  logic [IRQ_N-1:0]  irq_en,
  output logic [BANKS-1:0]  bank_empty,
  output logic [BANKS-1:0]  bank_full,
  output logic              irq
);
  import pp_fifo_pkg::*;

  logic [DATA_W-1:0] mem [BANKS][DEPTH];
  bank_st_e          st [BANKS];

  logic [BANK_W-1:0] wbank, rbank;
  logic [OFF_W-1:0]  woff, roff;
  logic              wlast, rlast;

  logic abort;
  logic wr_fire, rd_fire;
  logic [BANKS-1:0] wr_done_vec, rd_done_vec;

  assign abort    = wr_ptr_clr | rd_ptr_clr;
  assign wr_ready = !abort && bank_writable(st[wbank]);
  assign rd_valid = !abort && bank_readable(st[rbank]);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign rd_data  = mem[rbank][roff];

  pp_ptr #(.BANKS(BANKS), .DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(wr_ptr_clr), .adv(wr_fire),
    .bank_o(wbank), .off_o(woff), .last_o(wlast)
  );

  pp_ptr #(.BANKS(BANKS), .DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .clr(rd_ptr_clr), .adv(rd_fire),
    .bank_o(rbank), .off_o(roff), .last_o(rlast)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic whit, rhit;
    assign whit = wr_fire && (int'(wbank) == b);
    assign rhit = rd_fire && (int'(rbank) == b);
    assign wr_done_vec[b] = whit && wlast;
    assign rd_done_vec[b] = rhit && rlast;

    pp_bank_state u_st (
      .clk(clk), .rst_n(rst_n), .abort(abort),
      .wr_hit(whit), .wr_last(wlast), .rd_hit(rhit), .rd_last(rlast),
      .st_o(st[b])
    );

    assign bank_empty[b] = (st[b] == BK_EMPTY);
    assign bank_full[b]  = (st[b] == BK_FULL);

    always_ff @(posedge clk) begin
      if (whit) mem[b][woff] <= wr_data;
    end
  end

  pp_irq #(.SRCS(IRQ_N)) u_irq (
    .flags({bank_full, bank_empty}),
    .en(irq_en),
    .irq(irq)
  );

endmodule

// File: rtl/pp_fifo_chk.sv
module pp_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_ptr_clr,
  input logic              rd_ptr_clr,
  input logic [2*BANKS-1:0] irq_en,
  input logic [BANKS-1:0]  bank_empty,
  input logic [BANKS-1:0]  bank_full,
  input logic              irq,
  input logic [BANKS-1:0]  wr_done_vec,
  input logic [BANKS-1:0]  rd_done_vec
);

  a_r1_reset_flags: assert property (@(posedge clk) $rose(rst_n) |-> (&bank_empty) && (bank_full == '0));

  a_r3_full_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_done_vec) |=> ((bank_full & $past(wr_done_vec)) == $past(wr_done_vec)));

  a_r4_empty_after_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_done_vec) |=> ((bank_empty & $past(rd_done_vec)) == $past(rd_done_vec)));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_full & bank_empty) == '0);

  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_full) |-> !wr_ready);

  a_r7_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_empty) |-> !rd_valid);

  a_r2_data_held_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !wr_ptr_clr && !rd_ptr_clr) |=> $stable(rd_data));

  a_r9_wclr_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr_clr |-> (!wr_ready && !rd_valid));

  a_r10_rclr_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_clr |-> (!rd_valid && !wr_ready));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr_clr || rd_ptr_clr) |=> ((&bank_empty) && (bank_full == '0)));

  a_r11_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

endmodule

bind pingpong_fifo pp_fifo_chk #(.DATA_W(DATA_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .wr_ptr_clr(wr_ptr_clr),
  .rd_ptr_clr(rd_ptr_clr), .irq_en(irq_en), .bank_empty(bank_empty),
  .bank_full(bank_full), .irq(irq), .wr_done_vec(wr_done_vec),
  .rd_done_vec(rd_done_vec)
);

// File: tb/pingpong_fifo_tb.sv
module pingpong_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, rd_valid;
  logic [7:0] rd_data;
  logic       wr_ptr_clr = 0, rd_ptr_clr = 0;
  logic [3:0] irq_en = '0;
  logic [1:0] bank_empty, bank_full;
  logic       irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_ptr_clr(wr_ptr_clr), .rd_ptr_clr(rd_ptr_clr),
    .irq_en(irq_en), .bank_empty(bank_empty), .bank_full(bank_full), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    rd_ready = 1;
    while (!rd_valid) @(negedge clk);
    d = rd_data;
    @(posedge clk); #1;
    rd_ready = 0;
  endtask

  task automatic restart();
    @(negedge clk); wr_ptr_clr = 1; rd_ptr_clr = 1;
    @(negedge clk); wr_ptr_clr = 0; rd_ptr_clr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "empty", bank_empty, 2'b11);
    chk("R1", "full", bank_full, 2'b00);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_partial();
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
    @(negedge clk);
    chk("R3", "bank0 empty cleared", bank_empty, 2'b10);
    chk("R5", "partial bank not readable", rd_valid, 0);
    chk("R5", "no full on partial", bank_full, 2'b00);
    restart();
  endtask

  task automatic t_fill_drain();
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    @(negedge clk);
    chk("R3", "bank0 full", bank_full, 2'b01);
    for (int i = 8; i < 16; i++) push(8'h10 + 8'(i));
    @(negedge clk);
    chk("R3", "both full", bank_full, 2'b11);
    chk("R6", "wr_ready when full", wr_ready, 0);
    wr_valid = 1; wr_data = 8'hEE;
    repeat (3) @(negedge clk);
    chk("R6", "still stalled", wr_ready, 0);
    wr_valid = 0;
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R2", "order bank0", d, 8'h10 + i);
      if (i == 0) begin
        @(negedge clk);
        chk("R4", "full clears on first read", bank_full, 2'b10);
      end
    end
    @(negedge clk);
    chk("R4", "bank0 empty after drain", bank_empty, 2'b01);
    for (int i = 8; i < 16; i++) begin
      pop(d);
      if (d != 8'h10 + 8'(i)) bad++;
    end
    chk("R6", "bank1 intact after refused writes", bad, 0);
    @(negedge clk);
    chk("R7", "rd_valid when empty", rd_valid, 0);
    chk("R4", "all empty", bank_empty, 2'b11);
    repeat (2) @(negedge clk);
    chk("R7", "no duplicate byte", rd_valid, 0);
  endtask

  task automatic t_overlap();
    logic [7:0] d;
    int both = 0, dbad = 0;
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = 8'h80 + 8'(i); rd_ready = 1;
      #1;
      if (wr_ready && rd_valid) both++;
      if (rd_data != 8'h40 + 8'(i)) dbad++;
      @(posedge clk); #1;
      wr_valid = 0; rd_ready = 0;
    end
    chk("R8", "cycles with both accepted", both, 8);
    chk("R8", "bank0 bytes during overlap", dbad, 0);
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R8", "bank1 byte written in overlap", d, 8'h80 + i);
    end
  endtask

  task automatic t_irq();
    @(negedge clk);
    irq_en = 4'b0000; #1;
    chk("R11", "irq masked", irq, 0);
    irq_en = 4'b0001; #1;
    chk("R11", "irq bank0 empty", irq, 1);
    irq_en = 4'b0100; #1;
    chk("R11", "irq bank0 full not set", irq, 0);
    for (int i = 0; i < 8; i++) push(8'h55);
    @(negedge clk);
    chk("R11", "irq bank0 full", irq, 1);
    irq_en = 4'b1001; #1;
    chk("R11", "irq bank1 full/bank0 empty unset", irq, 0);
    irq_en = 4'b0010; #1;
    chk("R11", "irq bank1 empty", irq, 1);
    irq_en = 4'b0000;
    restart();
  endtask

  task automatic t_wclr();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) push(8'hC0 + 8'(i));
    @(negedge clk);
    wr_ptr_clr = 1; wr_valid = 1; wr_data = 8'hFF;
    #1;
    chk("R9", "wr_ready while clear", wr_ready, 0);
    @(negedge clk);
    chk("R9", "empty one cycle after clear", bank_empty, 2'b11);
    chk("R9", "rd_valid while clear", rd_valid, 0);
    wr_valid = 0; wr_ptr_clr = 0;
    for (int i = 0; i < 8; i++) push(8'h20 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R9", "restart at offset 0", d, 8'h20 + i);
    end
  endtask

  task automatic t_rclr();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) push(8'h60 + 8'(i));
    for (int i = 0; i < 3; i++) pop(d);
    @(negedge clk);
    rd_ptr_clr = 1; rd_ready = 1;
    #1;
    chk("R10", "rd_valid while clear", rd_valid, 0);
    chk("R10", "wr_ready while clear", wr_ready, 0);
    @(negedge clk);
    rd_ptr_clr = 0; rd_ready = 0;
    #1;
    chk("R10", "empty after read clear", bank_empty, 2'b11);
    chk("R10", "full after read clear", bank_full, 2'b00);
    chk("R10", "nothing to read", rd_valid, 0);
    restart();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_partial();
    t_fill_drain();
    t_overlap();
    t_irq();
    t_wclr();
    t_rclr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule